// File: doc/BRIEF.md
# DMA Burst Arbiter with Burst Sizing

This block shares one host bus master port between a receive DMA engine and a transmit DMA engine. Each cycle it is idle, it decides which engine may use the bus and how many 32-bit words the burst carries. It then holds that grant until the bus side reports the end of the burst. The receive engine drains a receive FIFO, so its available amount is the FIFO fill level. The transmit engine fills a transmit FIFO, so its available amount is the FIFO free space.

Two arbitration policies are chosen at run time by a plain mode pin. Fair mode alternates between the engines. Receive-first mode favours receive, except while a frame is leaving the transmitter. A programmed burst limit caps each burst. A limit of zero selects automatic sizing: the burst takes whatever the FIFO offers, but only once at least 16 words are available. The limit is written through a small write port that rejects illegal values. A one-cycle request strobe marks the start of every granted burst for the bus side. All pins are plain control and status; no data passes through the block.

Top module: `dma_burst_arb`

## Requirements
- R1: After reset, both grants, the request strobe, the stored burst limit and the error flag are all 0.
- R2: A write to the burst limit stores a legal value (0, 1, 2, 4, 8, 16 or 32) from the next cycle on. An illegal value is stored as 0 and sets a sticky error flag. Later legal writes do not clear the flag.
- R3: With a limit of 0, receive is eligible only when rx_fill is at least 16, and its burst length then equals rx_fill.
- R4: With a limit of 0, transmit is eligible only when tx_free is at least 16, and its burst length then equals tx_free.
- R5: With a nonzero limit, the burst length is the smaller of the limit and the available count. An engine whose available count is 0 is never granted.
- R6: In receive-first mode (rr_mode=0), when both engines are eligible, receive wins if tx_active is 0 and transmit wins if tx_active is 1. A single eligible engine is always served.
- R7: In fair mode (rr_mode=1), when both engines are eligible, the winner is the engine not served last. The last-served marker starts at transmit, so receive wins first.
- R8: A grant appears one cycle after the decision. At most one grant is high at a time. The grant and burst length stay unchanged, whatever the other inputs do, until burst_done is sampled high. At that edge both are cleared.
- R9: bus_req is high exactly in the first cycle of each grant and low otherwise.
- R10: A synchronous sw_rst returns every register to its R1 value in one cycle, including the last-served marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset |
| rr_mode | input | 1 | 1 = fair alternation, 0 = receive first |
| bl_wr_en | input | 1 | Write strobe for the burst limit |
| bl_wr_data | input | 6 | Burst limit value being written |
| rx_fill | input | 7 | Words held in the receive FIFO |
| tx_free | input | 7 | Free words in the transmit FIFO |
| tx_active | input | 1 | A frame is being transmitted |
| burst_done | input | 1 | Current burst has finished |
| gnt_rx | output | 1 | Bus granted to receive |
| gnt_tx | output | 1 | Bus granted to transmit |
| burst_len | output | 7 | Words in the granted burst, 0 when idle |
| bus_req | output | 1 | One-cycle bus request at the start of a grant |
| bl_value | output | 6 | Stored burst limit |
| bl_err | output | 1 | Sticky illegal-limit flag |

## Verification
The main check walks a table of cases that sweep the limit, the FIFO levels, the mode pin and the tx_active flag. Levels of 15 and 16 under automatic sizing separate the threshold from an off-by-one. Limits above and below the available count show whether the minimum is taken on the correct side. Both engines eligible with tx_active high and then low show whether the receive-first policy yields correctly. Back-to-back bursts with both engines eligible show fair alternation against fixed priority. A grant held while its inputs collapse shows that arbitration waits for the end of the burst.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_RX   = 2'b01,
    SRC_TX   = 2'b10
  } src_e;
endpackage

// File: rtl/dma_burst_cfg.sv
module dma_burst_cfg #(
  parameter int BLW    = 6,
  parameter int MAX_BL = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_rst,
  input  logic           wr_en,
  input  logic [BLW-1:0] wr_data,
  output logic [BLW-1:0] bl_q,
  output logic           err_q
);
  logic legal;

  // zero or a single power of two no larger than the cap
  always_comb
    legal = ((wr_data & (wr_data - 1'b1)) == '0) && (wr_data <= BLW'(MAX_BL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q  <= '0;
      err_q <= 1'b0;
    end else if (sw_rst) begin
      bl_q  <= '0;
      err_q <= 1'b0;
    end else if (wr_en) begin
      bl_q <= legal ? wr_data : '0;
      if (!legal) err_q <= 1'b1;
    end
  end

  // R2
  bl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((bl_q & (bl_q - 1'b1)) == '0) && (bl_q <= BLW'(MAX_BL))));
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !sw_rst) |=> err_q);
  // R10
  cfg_swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (bl_q == '0) && !err_q);
endmodule

// File: rtl/dma_burst_size.sv
module dma_burst_size #(
  parameter int CW       = 7,
  parameter int BLW      = 6,
  parameter int AUTO_MIN = 16
) (
  input  logic [CW-1:0]  avail,
  input  logic [BLW-1:0] bl,
  output logic [CW-1:0]  size,
  output logic           ok
);
  logic [CW-1:0] cap;

  always_comb begin
    cap = CW'(bl);
    if (bl == '0) begin
      size = avail;
      ok   = (avail >= CW'(AUTO_MIN));
    end else begin
      size = (avail < cap) ? avail : cap;
      ok   = (size != '0);
    end
  end
endmodule

// File: rtl/dma_arb_core.sv
module dma_arb_core
  import dma_arb_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          rr_mode,
  input  logic          tx_active,
  input  logic          rx_ok,
  input  logic          tx_ok,
  input  logic [CW-1:0] rx_size,
  input  logic [CW-1:0] tx_size,
  input  logic          burst_done,
  output logic          gnt_rx,
  output logic          gnt_tx,
  output logic [CW-1:0] burst_len,
  output logic          bus_req
);
  src_e          src_q, pick;
  logic          busy_q, req_q, last_tx_q;
  logic [CW-1:0] len_q;

  always_comb begin
    if (rx_ok && tx_ok) begin
      if (rr_mode) pick = last_tx_q ? SRC_RX : SRC_TX;
      else         pick = tx_active ? SRC_TX : SRC_RX;
    end else if (rx_ok) pick = SRC_RX;
    else if (tx_ok)     pick = SRC_TX;
    else                pick = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      src_q     <= SRC_NONE;
      len_q     <= '0;
      req_q     <= 1'b0;
      last_tx_q <= 1'b1;
    end else if (sw_rst) begin
      busy_q    <= 1'b0;
      src_q     <= SRC_NONE;
      len_q     <= '0;
      req_q     <= 1'b0;
      last_tx_q <= 1'b1;
    end else begin
      req_q <= 1'b0;
      if (busy_q) begin
        if (burst_done) begin
          busy_q <= 1'b0;
          src_q  <= SRC_NONE;
          len_q  <= '0;
        end
      end else if (pick != SRC_NONE) begin
        busy_q    <= 1'b1;
        src_q     <= pick;
        len_q     <= (pick == SRC_RX) ? rx_size : tx_size;
        req_q     <= 1'b1;
        last_tx_q <= (pick == SRC_TX);
      end
    end
  end

  assign gnt_rx    = (src_q == SRC_RX);
  assign gnt_tx    = (src_q == SRC_TX);
  assign burst_len = len_q;
  assign bus_req   = req_q;

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    ((gnt_rx || gnt_tx) && !burst_done) |=> ($stable(src_q) && $stable(len_q)));
  // R8
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    ((gnt_rx || gnt_tx) && burst_done) |=> (!gnt_rx && !gnt_tx));
  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_tx, gnt_rx}));
  // R5
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_rx || gnt_tx) |-> (burst_len != '0));
  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !bus_req);
  // R9
  req_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (gnt_rx || gnt_tx));
  // R10
  core_swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!gnt_rx && !gnt_tx && !bus_req && burst_len == '0));
endmodule

// File: rtl/dma_burst_arb.sv
module dma_burst_arb #(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_BL     = 32,
  parameter int AUTO_MIN   = 16,
  parameter int BLW        = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sw_rst,
  input  logic                            rr_mode,
  input  logic                            bl_wr_en,
  input  logic [BLW-1:0]                  bl_wr_data,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] rx_fill,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] tx_free,
  input  logic                            tx_active,
  input  logic                            burst_done,
  output logic                            gnt_rx,
  output logic                            gnt_tx,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] burst_len,
  output logic                            bus_req,
  output logic [BLW-1:0]                  bl_value,
  output logic                            bl_err
);
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int NCH  = 2;

  logic [BLW-1:0] bl_q;
  logic [CW-1:0]  avail [NCH];
  logic [CW-1:0]  size  [NCH];
  logic           ok    [NCH];

  dma_burst_cfg #(.BLW(BLW), .MAX_BL(MAX_BL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .wr_en(bl_wr_en), .wr_data(bl_wr_data),
    .bl_q(bl_q), .err_q(bl_err)
  );

  assign avail[0] = rx_fill;
  assign avail[1] = tx_free;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_size
    dma_burst_size #(.CW(CW), .BLW(BLW), .AUTO_MIN(AUTO_MIN)) u_size (
      .avail(avail[ch]), .bl(bl_q), .size(size[ch]), .ok(ok[ch])
    );
  end

  dma_arb_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .rr_mode(rr_mode), .tx_active(tx_active),
    .rx_ok(ok[0]), .tx_ok(ok[1]),
    .rx_size(size[0]), .tx_size(size[1]),
    .burst_done(burst_done),
    .gnt_rx(gnt_rx), .gnt_tx(gnt_tx),
    .burst_len(burst_len), .bus_req(bus_req)
  );

  assign bl_value = bl_q;
endmodule

// File: tb/tb_dma_burst_arb.sv
module tb_dma_burst_arb;
  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0, rr_mode = 1'b0;
  logic bl_wr_en = 1'b0, tx_active = 1'b0, burst_done = 1'b0;
  logic [5:0] bl_wr_data = '0;
  logic [6:0] rx_fill = '0, tx_free = '0;
  logic gnt_rx, gnt_tx, bus_req, bl_err;
  logic [6:0] burst_len;
  logic [5:0] bl_value;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_burst_arb dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rr_mode(rr_mode),
    .bl_wr_en(bl_wr_en), .bl_wr_data(bl_wr_data), .rx_fill(rx_fill),
    .tx_free(tx_free), .tx_active(tx_active), .burst_done(burst_done),
    .gnt_rx(gnt_rx), .gnt_tx(gnt_tx), .burst_len(burst_len),
    .bus_req(bus_req), .bl_value(bl_value), .bl_err(bl_err)
  );

  // fields: rr[30] bl[29:24] rx[23:17] tx[16:10] act[9] gnt[8:7] (1=rx,2=tx,0=none) len[6:0]
  localparam logic [30:0] VEC [12] = '{
    {1'b0, 6'd0,  7'd20, 7'd30, 1'b0, 2'd1, 7'd20}, // R3 R6
    {1'b0, 6'd0,  7'd15, 7'd30, 1'b0, 2'd2, 7'd30}, // R3 R4 below threshold
    {1'b0, 6'd0,  7'd15, 7'd15, 1'b0, 2'd0, 7'd0 }, // R3 R4 neither
    {1'b0, 6'd0,  7'd16, 7'd16, 1'b0, 2'd1, 7'd16}, // R3 exact threshold
    {1'b0, 6'd0,  7'd40, 7'd40, 1'b1, 2'd2, 7'd40}, // R4 R6 tx_active yields
    {1'b0, 6'd8,  7'd3,  7'd40, 1'b0, 2'd1, 7'd3 }, // R5 avail below limit
    {1'b0, 6'd8,  7'd20, 7'd40, 1'b0, 2'd1, 7'd8 }, // R5 limit caps
    {1'b0, 6'd4,  7'd0,  7'd2,  1'b0, 2'd2, 7'd2 }, // R5 rx empty
    {1'b0, 6'd32, 7'd0,  7'd0,  1'b0, 2'd0, 7'd0 }, // R5 nothing available
    {1'b1, 6'd0,  7'd20, 7'd20, 1'b0, 2'd1, 7'd20}, // R7 first fair pick is rx
    {1'b0, 6'd1,  7'd5,  7'd5,  1'b1, 2'd2, 7'd1 }, // R5 R6
    {1'b1, 6'd16, 7'd0,  7'd50, 1'b1, 2'd2, 7'd16}  // R7 single eligible
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gcode();
    return {30'd0, gnt_tx, gnt_rx};
  endfunction

  task automatic write_bl(logic [5:0] v);
    bl_wr_en = 1'b1; bl_wr_data = v; tick(); bl_wr_en = 1'b0;
  endtask

  task automatic release_bus();
    burst_done = 1'b1; tick(); burst_done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (2) tick();
    rst_n = 1'b1; tick();
    // R1 reset state
    check("R1 grant", gcode(), 0);
    check("R1 bus_req", bus_req, 0);
    check("R1 bl_value", bl_value, 0);
    check("R1 bl_err", bl_err, 0);

    foreach (VEC[i]) begin
      sw_rst = 1'b1; rx_fill = '0; tx_free = '0; tick(); sw_rst = 1'b0;
      write_bl(VEC[i][29:24]);
      rr_mode = VEC[i][30]; rx_fill = VEC[i][23:17];
      tx_free = VEC[i][16:10]; tx_active = VEC[i][9];
      tick();
      check($sformatf("R3-R7 vec%0d grant", i), gcode(), int'(VEC[i][8:7]));
      check($sformatf("R5 vec%0d len", i), burst_len, int'(VEC[i][6:0]));
      check($sformatf("R9 vec%0d req", i), bus_req, VEC[i][8:7] != 0);
      rx_fill = '0; tx_free = '0; tx_active = 1'b0;
      release_bus(); tick();
      check($sformatf("R8 vec%0d released", i), gcode(), 0);
    end

    // R8 R9 hold and strobe
    sw_rst = 1'b1; tick(); sw_rst = 1'b0;
    rr_mode = 1'b0; rx_fill = 7'd40; tx_free = 7'd40; tick();
    check("R9 req first cycle", bus_req, 1);
    rx_fill = '0; tx_active = 1'b1; tick();
    check("R9 req dropped", bus_req, 0);
    check("R8 grant held", gcode(), 1);
    check("R8 len held", burst_len, 40);
    tick();
    check("R8 still held", gcode(), 1);
    tx_active = 1'b0; rx_fill = 7'd40;

    // R6 receive-first repeats
    release_bus(); tick();
    check("R6 rx again", gcode(), 1);
    release_bus(); tick();
    check("R6 rx third", gcode(), 1);

    // R7 alternation
    rr_mode = 1'b1;
    release_bus(); tick();
    check("R7 alternate to tx", gcode(), 2);
    release_bus(); tick();
    check("R7 alternate to rx", gcode(), 1);
    release_bus(); tick();
    check("R7 alternate to tx again", gcode(), 2);

    // R10 software reset mid-grant, marker back to tx
    release_bus(); tick();
    check("R7 rx before reset", gcode(), 1);
    write_bl(6'd3);
    check("R2 illegal stored zero", bl_value, 0);
    check("R2 err set", bl_err, 1);
    sw_rst = 1'b1; tick(); sw_rst = 1'b0;
    check("R10 grant cleared", gcode(), 0);
    check("R10 err cleared", bl_err, 0);
    check("R10 req low", bus_req, 0);
    tick();
    check("R10 marker reset rx first", gcode(), 1);
    rx_fill = '0; tx_free = '0; release_bus();

    // R2 sticky error
    write_bl(6'd16);
    check("R2 legal stored", bl_value, 16);
    write_bl(6'd48);
    check("R2 over cap stored zero", bl_value, 0);
    write_bl(6'd8);
    check("R2 legal after illegal", bl_value, 8);
    check("R2 err sticky", bl_err, 1);
    write_bl(6'd32);
    check("R2 max legal", bl_value, 32);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule